// File: doc/BRIEF.md
# Boundary-Scan Register Chain for a 32-bit Data Bus Device

This block is the boundary-scan data register of a device with 32 bidirectional data lines and 37 observe-only inputs (address, strobes, parity and a few single-bit controls). It holds 89 scan cells in a fixed order between the serial input and the serial output. A separate test access port controller drives its shift, capture, update, mode and tristate-force strobes. The pad circuitry is outside the block: each data line is represented by a value bit and an enable bit, and an enable of 0 stands for high impedance.

Each shift cell samples its pin side when capture is requested and moves one place toward the serial output when shift is requested. Only the 32 data cells and one output-control cell have an update stage. These update latches load on the falling clock edge. In test mode they drive the data pins, and the single control latch enables or disables all 32 drivers together. Outside test mode, the core's data and enables pass straight to the pads. A force input turns every data driver off in either mode.

Top module: `bsr_chain`

## Requirements
- R1: The chain has 89 cells. `scan_in` enters cell 0 and `scan_out` shows cell 88. On each rising `tck` edge with `shift_en` high and `capture_en` low, every cell takes the value of the cell one position nearer `scan_in`.
- R2: On a rising `tck` edge with `capture_en` high, each cell loads its pin side, and this takes priority over `shift_en`. An input cell loads its pin. A data cell loads `pad_in`. A placeholder cell loads 0. Cell 88 loads the current value of its own update latch.
- R3: Data bit k sits in cell B+(k mod 8), where B is 13, 23, 57 or 67 for byte lane k/8 = 0, 1, 2 or 3. The placeholder cells are 0–3, 21, 22, 32, 33, 38, 53–55, 65, 66, 76, 77, 79, 82 and 85. Cell 88 is the control cell. The remaining 37 cells are input cells, and `in_pins[j]` belongs to the j-th of them counted upward from cell 0.
- R4: The 33 update latches (32 data, 1 control) load from their shift cells on a falling `tck` edge with `update_en` high. They hold their value on every other edge, including while shifting.
- R5: With `test_mode` high and `force_hiz` low, `pad_out[k]` equals the update latch of data bit k, and every bit of `pad_oe` equals the control latch. The core data and core enables then have no effect on the pads.
- R6: With `test_mode` low and `force_hiz` low, `pad_out` equals `core_out` and `pad_oe` equals `core_oe`.
- R7: With `force_hiz` high, `pad_oe` is all zeros in both modes.
- R8: A low `rst_n` (synchronous) clears all shift cells and all update latches. After reset `scan_out` is 0 and in test mode every data driver is off.
- R9: `core_in` always equals `pad_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; shift and capture on rising edge, update on falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_en | input | 1 | Shift the chain one place toward `scan_out` |
| capture_en | input | 1 | Load every cell from its pin side |
| update_en | input | 1 | Load update latches on the falling edge |
| test_mode | input | 1 | Pads driven from update latches when high |
| force_hiz | input | 1 | Turns all data drivers off |
| scan_in | input | 1 | Serial data into cell 0 |
| scan_out | output | 1 | Serial data from cell 88 |
| in_pins | input | 37 | Observe-only input pins in chain order |
| pad_in | input | 32 | Values seen on the data pads |
| core_out | input | 32 | Data the core wants to drive |
| core_oe | input | 32 | Per-line core output enable |
| core_in | output | 32 | Pad values handed to the core |
| pad_out | output | 32 | Value to drive on each data pad |
| pad_oe | output | 32 | Per-line pad driver enable |

## Verification
The assertions assume that the controller never raises `update_en` in the same cycle as a shift or capture that it expects the latches to see. They also assume that all strobes change only after the rising edge, so that the falling edge in between sees a settled value. The stimulus sets every strobe one nanosecond after a rising edge and holds it for a whole cycle. It also keeps update pulses apart from shift and capture cycles. In this way the latched value is always the chain contents left by the preceding rising edge.

// File: rtl/bsr_pkg.sv
// Package: chain geometry and cell classification for the boundary-scan
// register. Assumes the fixed 89-cell layout; all position queries are
// computed by constant functions so no table is written out.
package bsr_pkg;

    localparam int CHAIN_LEN = 89;
    localparam int LANES     = 4;
    localparam int LANE_W    = 8;
    localparam int DATA_W    = LANES * LANE_W;
    localparam int CTRL_CELL = CHAIN_LEN - 1;

    typedef enum logic [1:0] {
        CK_SPARE   = 2'd0,
        CK_OBSERVE = 2'd1,
        CK_DATA    = 2'd2,
        CK_CONTROL = 2'd3
    } cell_kind_e;

    // First chain position of each byte lane.
    function automatic int lane_base(input int lane);
        case (lane)
            0:       return 13;
            1:       return 23;
            2:       return 57;
            default: return 67;
        endcase
    endfunction

    // Placeholder positions that hold no pin.
    function automatic bit is_spare(input int c);
        return (c <= 3) || (c == 21) || (c == 22) || (c == 32) || (c == 33) ||
               (c == 38) || (c >= 53 && c <= 55) || (c == 65) || (c == 66) ||
               (c == 76) || (c == 77) || (c == 79) || (c == 82) || (c == 85);
    endfunction

    // Classify one chain position.
    function automatic cell_kind_e kind_of(input int c);
        if (c == CTRL_CELL) return CK_CONTROL;
        for (int l = 0; l < LANES; l++)
            if (c >= lane_base(l) && c < lane_base(l) + LANE_W) return CK_DATA;
        if (is_spare(c)) return CK_SPARE;
        return CK_OBSERVE;
    endfunction

    // Data bit index held by a data cell.
    function automatic int bit_of(input int c);
        for (int l = 0; l < LANES; l++)
            if (c >= lane_base(l) && c < lane_base(l) + LANE_W)
                return l * LANE_W + (c - lane_base(l));
        return 0;
    endfunction

    // Chain position of data bit k.
    function automatic int cell_of_bit(input int k);
        return lane_base(k / LANE_W) + (k % LANE_W);
    endfunction

    // Number of observe cells strictly below position c.
    function automatic int observe_ordinal(input int c);
        int n;
        n = 0;
        for (int i = 0; i < c; i++)
            if (kind_of(i) == CK_OBSERVE) n++;
        return n;
    endfunction

    localparam int NUM_OBS = observe_ordinal(CHAIN_LEN);

endpackage

// File: rtl/bsr_shift_path.sv
// Shift/capture stage of the chain. Captures a parallel word or shifts
// toward the output end on the rising clock edge; capture wins if both
// strobes are high. Exposes selected cells as taps for the update stage.
// Assumes strobes are stable around the rising edge.
module bsr_shift_path
    import bsr_pkg::*;
#(
    parameter int LEN    = CHAIN_LEN,
    parameter int TAPS_W = DATA_W + 1
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              capture_en,
    input  logic              scan_in,
    input  logic [LEN-1:0]    cap_d,
    output logic              scan_out,
    output logic [TAPS_W-1:0] tap_q
);

    logic [LEN-1:0] sr_q;

    // Chain register: reset, capture, or shift by one place.
    always_ff @(posedge tck) begin
        if (!rst_n)          sr_q <= '0;
        else if (capture_en) sr_q <= cap_d;
        else if (shift_en)   sr_q <= {sr_q[LEN-2:0], scan_in};
    end

    assign scan_out = sr_q[LEN-1];

    // Tap out the data cells and the control cell for the update latches.
    for (genvar k = 0; k < TAPS_W - 1; k++) begin : g_tap
        assign tap_q[k] = sr_q[cell_of_bit(k)];
    end
    assign tap_q[TAPS_W-1] = sr_q[CTRL_CELL];

endmodule

// File: rtl/bsr_update_bank.sv
// Update latches for cells that drive pins. Load on the falling clock
// edge when update is requested, otherwise hold. Assumes update_en is
// set up before the falling edge.
module bsr_update_bank #(
    parameter int W = 33
) (
    input  logic         tck,
    input  logic         rst_n,
    input  logic         update_en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Falling-edge update register with synchronous clear.
    always_ff @(negedge tck) begin
        if (!rst_n)         q <= '0;
        else if (update_en) q <= d;
    end

endmodule

// File: rtl/bsr_pin_mux.sv
// Pad-side selection for the data lines: core path in normal mode,
// update latches in test mode, every driver off under force. Purely
// combinational.
module bsr_pin_mux #(
    parameter int W = 32
) (
    input  logic         test_mode,
    input  logic         force_hiz,
    input  logic [W-1:0] upd_data,
    input  logic         upd_ctrl,
    input  logic [W-1:0] core_out,
    input  logic [W-1:0] core_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);

    for (genvar k = 0; k < W; k++) begin : g_line
        // Per-line value and enable selection.
        always_comb begin
            pad_out[k] = test_mode ? upd_data[k] : core_out[k];
            if (force_hiz)      pad_oe[k] = 1'b0;
            else if (test_mode) pad_oe[k] = upd_ctrl;
            else                pad_oe[k] = core_oe[k];
        end
    end

endmodule

// File: rtl/bsr_chain.sv
// Top of the boundary-scan register. Routes each cell's capture source by
// its kind, connects the shift path, the update bank and the pad mux.
// Assumes a controller issues one strobe kind per cycle and that the
// pads interpret a 0 enable as high impedance.
module bsr_chain
    import bsr_pkg::*;
#(
    parameter logic SPARE_CAPTURE = 1'b0
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               capture_en,
    input  logic               update_en,
    input  logic               test_mode,
    input  logic               force_hiz,
    input  logic               scan_in,
    output logic               scan_out,
    input  logic [NUM_OBS-1:0] in_pins,
    input  logic [DATA_W-1:0]  pad_in,
    input  logic [DATA_W-1:0]  core_out,
    input  logic [DATA_W-1:0]  core_oe,
    output logic [DATA_W-1:0]  core_in,
    output logic [DATA_W-1:0]  pad_out,
    output logic [DATA_W-1:0]  pad_oe
);

    localparam int UPD_W = DATA_W + 1;

    logic [CHAIN_LEN-1:0] cap_d;
    logic [UPD_W-1:0]     tap_q;
    logic [UPD_W-1:0]     upd_q;

    // Capture source per cell, chosen by its kind.
    for (genvar c = 0; c < CHAIN_LEN; c++) begin : g_cell
        if (kind_of(c) == CK_OBSERVE) begin : g_obs
            assign cap_d[c] = in_pins[observe_ordinal(c)];
        end else if (kind_of(c) == CK_DATA) begin : g_dat
            assign cap_d[c] = pad_in[bit_of(c)];
        end else if (kind_of(c) == CK_CONTROL) begin : g_ctl
            assign cap_d[c] = upd_q[UPD_W-1];
        end else begin : g_spr
            assign cap_d[c] = SPARE_CAPTURE;
        end
    end

    bsr_shift_path #(.LEN(CHAIN_LEN), .TAPS_W(UPD_W)) u_shift (
        .tck        (tck),
        .rst_n      (rst_n),
        .shift_en   (shift_en),
        .capture_en (capture_en),
        .scan_in    (scan_in),
        .cap_d      (cap_d),
        .scan_out   (scan_out),
        .tap_q      (tap_q)
    );

    bsr_update_bank #(.W(UPD_W)) u_upd (
        .tck       (tck),
        .rst_n     (rst_n),
        .update_en (update_en),
        .d         (tap_q),
        .q         (upd_q)
    );

    bsr_pin_mux #(.W(DATA_W)) u_mux (
        .test_mode (test_mode),
        .force_hiz (force_hiz),
        .upd_data  (upd_q[DATA_W-1:0]),
        .upd_ctrl  (upd_q[UPD_W-1]),
        .core_out  (core_out),
        .core_oe   (core_oe),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    // Observed data always reaches the core.
    assign core_in = pad_in;

endmodule

// File: rtl/bsr_chain_chk.sv
// Checker bound to bsr_chain: temporal relations between strobes, the
// chain taps, the update latches and the pads.
module bsr_chain_chk
    import bsr_pkg::*;
(
    input logic              tck,
    input logic              rst_n,
    input logic              shift_en,
    input logic              capture_en,
    input logic              update_en,
    input logic              test_mode,
    input logic              force_hiz,
    input logic              scan_out,
    input logic [DATA_W-1:0] pad_in,
    input logic [DATA_W-1:0] core_out,
    input logic [DATA_W-1:0] core_oe,
    input logic [DATA_W:0]   tap_q,
    input logic [DATA_W:0]   upd_q,
    input logic [DATA_W-1:0] pad_out,
    input logic [DATA_W-1:0] pad_oe
);

    // R1: cell 14 takes cell 13 on a shift.
    a_r1_shift_step: assert property (@(posedge tck) disable iff (!rst_n)
        (shift_en && !capture_en) |=> (tap_q[1] == $past(tap_q[0])));

    // R2: control cell captures its own update value.
    a_r2_ctrl_capture: assert property (@(posedge tck) disable iff (!rst_n)
        capture_en |=> (scan_out == $past(upd_q[DATA_W])));

    // R2: data cells capture the pads.
    a_r2_data_capture: assert property (@(posedge tck) disable iff (!rst_n)
        capture_en |=> (tap_q[DATA_W-1:0] == $past(pad_in)));

    // R4: latches hold without update.
    a_r4_hold: assert property (@(posedge tck) disable iff (!rst_n)
        !update_en |-> $stable(upd_q));

    // R4: latches follow the chain after an update.
    a_r4_load: assert property (@(posedge tck) disable iff (!rst_n)
        update_en |-> (upd_q == tap_q));

    // R5: control latch at 0 disables all drivers in test mode.
    a_r5_ctrl_off: assert property (@(posedge tck) disable iff (!rst_n)
        (test_mode && !upd_q[DATA_W]) |-> (pad_oe == '0));

    // R6: normal mode passes core signals.
    a_r6_pass: assert property (@(posedge tck) disable iff (!rst_n)
        (!test_mode && !force_hiz) |-> (pad_out == core_out && pad_oe == core_oe));

    // R7: force turns every driver off.
    a_r7_force: assert property (@(posedge tck) disable iff (!rst_n)
        force_hiz |-> (pad_oe == '0));

endmodule

bind bsr_chain bsr_chain_chk u_chk (
    .tck        (tck),
    .rst_n      (rst_n),
    .shift_en   (shift_en),
    .capture_en (capture_en),
    .update_en  (update_en),
    .test_mode  (test_mode),
    .force_hiz  (force_hiz),
    .scan_out   (scan_out),
    .pad_in     (pad_in),
    .core_out   (core_out),
    .core_oe    (core_oe),
    .tap_q      (tap_q),
    .upd_q      (upd_q),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe)
);

// File: tb/sim_bsr_chain.sv
`timescale 1ns/1ps
module sim_bsr_chain;

    logic        tck = 1'b0;
    logic        rst_n, shift_en, capture_en, update_en, test_mode, force_hiz, scan_in;
    logic        scan_out;
    logic [36:0] in_pins;
    logic [31:0] pad_in, core_out, core_oe, core_in, pad_out, pad_oe;

    int errors = 0;
    int checks = 0;

    always #2.5 tck = ~tck;

    bsr_chain u0 (
        .tck(tck), .rst_n(rst_n), .shift_en(shift_en), .capture_en(capture_en),
        .update_en(update_en), .test_mode(test_mode), .force_hiz(force_hiz),
        .scan_in(scan_in), .scan_out(scan_out), .in_pins(in_pins), .pad_in(pad_in),
        .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Layout from R3, written independently.
    function automatic int base_of(input int lane);
        int b[4] = '{13, 23, 57, 67};
        return b[lane];
    endfunction

    function automatic bit spare_pos(input int c);
        int s[19] = '{0,1,2,3,21,22,32,33,38,53,54,55,65,66,76,77,79,82,85};
        foreach (s[i]) if (s[i] == c) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [88:0] exp_cap(input logic [36:0] pins, input logic [31:0] pad, input logic ctl);
        logic [88:0] v;
        int ord;
        ord = 0;
        v = '0;
        for (int c = 0; c < 89; c++) begin
            bit done;
            done = 1'b0;
            for (int l = 0; l < 4; l++)
                if (c >= base_of(l) && c < base_of(l) + 8) begin
                    v[c] = pad[l*8 + c - base_of(l)];
                    done = 1'b1;
                end
            if (!done) begin
                if (c == 88)           v[c] = ctl;
                else if (spare_pos(c)) v[c] = 1'b0;
                else begin v[c] = pins[ord]; ord++; end
            end
        end
        return v;
    endfunction

    function automatic logic [31:0] data_of(input logic [88:0] v);
        logic [31:0] d;
        for (int k = 0; k < 32; k++) d[k] = v[base_of(k/8) + k%8];
        return d;
    endfunction

    task automatic tick();
        @(posedge tck);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [88:0] act, input logic [88:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic scan(input logic [88:0] din, output logic [88:0] got);
        shift_en = 1'b1;
        for (int j = 0; j < 89; j++) begin
            got[88-j] = scan_out;
            scan_in = din[88-j];
            tick();
        end
        shift_en = 1'b0;
        scan_in = 1'b0;
    endtask

    task automatic do_capture();
        capture_en = 1'b1;
        tick();
        capture_en = 1'b0;
    endtask

    task automatic do_update();
        update_en = 1'b1;
        tick();
        update_en = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [88:0] got, din1, din2, e;
        logic [31:0] held;
        rst_n = 0; shift_en = 0; capture_en = 0; update_en = 0; test_mode = 0;
        force_hiz = 0; scan_in = 0; in_pins = '0; pad_in = '0; core_out = '0; core_oe = '0;
        repeat (3) tick();
        rst_n = 1;
        tick();

        // R8: reset state
        check(scan_out == 1'b0, "R8", "scan_out after reset", 89'(scan_out), 89'(0));
        test_mode = 1; #1;
        check(pad_oe == '0 && pad_out == '0, "R8", "test-mode pads after reset",
              {pad_oe, pad_out}, 89'(0));
        test_mode = 0;

        // R2/R3: walking one over every input and data pin, control latch 0
        for (int b = 0; b < 69; b++) begin
            in_pins = (b < 37) ? (37'(1) << b) : '0;
            pad_in  = (b >= 37) ? (32'(1) << (b - 37)) : '0;
            do_capture();
            scan(89'(0), got);
            e = exp_cap(in_pins, pad_in, 1'b0);
            check(got == e, "R3", "walking-one capture", got, e);
        end

        // R2/R1: several arithmetic patterns
        for (int p = 1; p < 9; p++) begin
            in_pins = 37'(p * 64'h1F3A5C7E9) ^ 37'h0AAAAAAAAA;
            pad_in  = 32'(p) * 32'h9E3779B1;
            do_capture();
            scan(89'(0), got);
            e = exp_cap(in_pins, pad_in, 1'b0);
            check(got == e, "R2", "pattern capture", got, e);
        end

        // R1: shift-through with no capture returns what was shifted in
        din1 = {25'h1ABCDEF, 64'h0123456789ABCDEF};
        scan(din1, got);
        scan(89'(0), got);
        check(got == din1, "R1", "shift-through", got, din1);

        // R4/R5: load data and enable drivers
        din1 = '0;
        din1[88] = 1'b1;
        for (int k = 0; k < 32; k++) din1[base_of(k/8) + k%8] = k[0] ^ k[2];
        scan(din1, got);
        do_update();
        test_mode = 1; core_out = 32'hFFFF0000; core_oe = '0; #1;
        check(pad_out == data_of(din1), "R5", "pad_out from latches", 89'(pad_out), 89'(data_of(din1)));
        check(pad_oe == '1, "R5", "enables from control latch", 89'(pad_oe), 89'(32'hFFFFFFFF));
        held = pad_out;

        // R2: control cell captures its latch (1), while shifting new data in
        in_pins = 37'h155; pad_in = 32'h0F0F1234;
        do_capture();
        din2 = ~din1;
        din2[88] = 1'b0;
        scan(din2, got);
        e = exp_cap(in_pins, pad_in, 1'b1);
        check(got == e, "R2", "control cell captures latch", got, e);
        check(pad_out == held && pad_oe == '1, "R4", "latches hold during shift",
              {pad_oe, pad_out}, {32'hFFFFFFFF, held});

        // R4/R5: update with control 0
        do_update();
        check(pad_out == data_of(din2), "R4", "update loads new data", 89'(pad_out), 89'(data_of(din2)));
        check(pad_oe == '0, "R5", "control 0 disables drivers", 89'(pad_oe), 89'(0));

        // R7: force in both modes
        scan(din1, got);
        do_update();
        force_hiz = 1; #1;
        check(pad_oe == '0, "R7", "force in test mode", 89'(pad_oe), 89'(0));
        test_mode = 0; core_oe = '1; #1;
        check(pad_oe == '0, "R7", "force in normal mode", 89'(pad_oe), 89'(0));
        force_hiz = 0;

        // R6/R9: normal-mode sweep
        for (int i = 0; i < 256; i++) begin
            core_out = 32'(i) * 32'h9E3779B1;
            core_oe  = ~(32'(i) * 32'h85EBCA6B);
            pad_in   = 32'(i) * 32'hC2B2AE35;
            #1;
            check(pad_out == core_out && pad_oe == core_oe, "R6", "normal pass-through",
                  {pad_oe, pad_out}, {core_oe, core_out});
            check(core_in == pad_in, "R9", "core_in follows pad", 89'(core_in), 89'(pad_in));
        end

        // R5: in test mode the core has no effect
        test_mode = 1;
        for (int i = 0; i < 16; i++) begin
            core_out = 32'(i) * 32'h01234567; core_oe = 32'(i) * 32'h89ABCDEF; #1;
            check(pad_out == data_of(din1) && pad_oe == '1, "R5", "core ignored in test mode",
                  {pad_oe, pad_out}, {32'hFFFFFFFF, data_of(din1)});
        end
        test_mode = 0;

        // R2: capture wins over shift in the same cycle
        in_pins = 37'h1234567890; pad_in = 32'hA5C3E187;
        shift_en = 1; capture_en = 1; scan_in = 1;
        tick();
        shift_en = 0; capture_en = 0; scan_in = 0;
        scan(89'(0), got);
        e = exp_cap(in_pins, pad_in, 1'b1);
        check(got == e, "R2", "capture priority over shift", got, e);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule